// File: doc/BRIEF.md
# Single-Precision Float to Signed Integer Converter (Truncating)

This block turns a 32-bit IEEE-754 single-precision word into a 32-bit two's-complement integer, rounding toward zero. It splits the word into sign, biased exponent and fraction, and restores the hidden leading one. It then works out how far the resulting 24-bit significand must move so that its binary point lands at the integer boundary. The significand is moved left or right by that amount, and the sign is applied last.

Values too small to reach the units bit flush to zero. Values whose magnitude cannot be held in the destination give the most negative integer, whatever their sign, and raise an out-of-range flag. Infinities and NaNs take this same path. The unit is registered once: a word presented with its valid strobe shows up converted on the outputs after the next rising clock edge.

Top module: `float_to_int_trunc`

## Requirements
- R1: The input word carries the sign in bit 31, an 8-bit exponent biased by 127 in bits 30:23 and a 23-bit fraction in bits 22:0, with an implied leading one; a value that is a whole number in range converts exactly (0x3F800000 gives 1, 0x4B7FFFFF gives 16777215, 0x4EFFFFFF gives 2147483520).
- R2: Any fractional part is discarded toward zero (2.75 gives 2, 0.999 gives 0, -2.75 gives -2), with the flag clear.
- R3: An exponent field of 118 or less (right shift of 32 or more), including zero and subnormal inputs, gives result 0 with the flag clear.
- R4: An exponent field from 158 to 254 gives result 0x80000000 with the flag set, for either sign, except the case of R5.
- R5: The word 0xCF000000 (exactly -2^31) gives 0x80000000 with the flag clear.
- R6: An exponent field of 255 (infinity or NaN) gives 0x80000000 with the flag set.
- R7: A set sign bit on an in-range input yields the two's-complement negation of the truncated magnitude.
- R8: outValid is high in exactly the cycles that follow a cycle with inValid high; while inValid is low, outInt and outOvf keep their previous values.
- R9: During reset outValid, outInt and outOvf are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Qualifies inWord in this cycle |
| inWord | input | 32 | Single-precision input word |
| outValid | output | 1 | Result of the previous cycle's word is on outInt |
| outInt | output | 32 | Converted two's-complement integer |
| outOvf | output | 1 | Input was out of range, infinite or NaN |

## Verification
The hardest situations to reach are the edges of the exponent window: 118 against 119, 157 against 158, and the single word at exponent 158 that must not be flagged. A uniform 32-bit draw lands in the useful exponent band only rarely. The random stimulus therefore forces the exponent field into the range 100 to 179 for most draws. Directed words pin down each boundary exponent in both signs, together with the all-ones and all-zeros fraction, the exact -2^31 word, infinities, NaN and subnormals.

// File: rtl/f2i_pkg.sv
package f2i_pkg;

  // Strobes from control to datapath; at most one of the four action bits is set.
  typedef struct packed {
    logic flushZero;
    logic shiftRight;
    logic shiftLeft;
    logic overflow;
    logic negate;
  } alignCtl_t;

endpackage

// File: rtl/f2i_ctrl.sv
module f2i_ctrl
  import f2i_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int INT_W  = 32,
  parameter int SH_W   = 5
) (
  input  logic             signBit,
  input  logic [EXP_W-1:0] expField,
  input  logic             fracZero,
  output alignCtl_t        ctl,
  output logic [SH_W-1:0]  shiftAmt
);

  localparam int BIAS   = (2 ** (EXP_W - 1)) - 1;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int SE_W   = EXP_W + 2;
  localparam int OFFSET = BIAS + FRAC_W;

  // Signed limits on the effective shift (exponent field minus bias and fraction width).
  localparam logic signed [SE_W-1:0] SHIFT_OFS = SE_W'(OFFSET);
  localparam logic signed [SE_W-1:0] FLUSH_LIM = SE_W'(-INT_W);
  localparam logic signed [SE_W-1:0] OVF_LIM   = SE_W'(INT_W - SIG_W);

  logic signed [SE_W-1:0] effShift;
  logic                   expAllOnes;
  logic                   expZero;
  logic                   exactMin;

  assign effShift   = $signed({2'b00, expField}) - SHIFT_OFS;
  assign expAllOnes = &expField;
  assign expZero    = ~|expField;
  // Magnitude 2^(INT_W-1) with a negative sign is the only value at the limit that fits.
  assign exactMin   = signBit && fracZero && (effShift == OVF_LIM);

  always_comb begin
    ctl      = '0;
    shiftAmt = '0;
    if (expAllOnes) begin
      ctl.overflow = 1'b1;
    end else if (expZero || (effShift <= FLUSH_LIM)) begin
      ctl.flushZero = 1'b1;
    end else if (effShift < 0) begin
      ctl.shiftRight = 1'b1;
      ctl.negate     = signBit;
      shiftAmt       = SH_W'(-effShift);
    end else if ((effShift >= OVF_LIM) && !exactMin) begin
      ctl.overflow = 1'b1;
    end else begin
      ctl.shiftLeft = 1'b1;
      ctl.negate    = signBit;
      shiftAmt      = SH_W'(effShift);
    end
  end

endmodule

// File: rtl/f2i_align.sv
module f2i_align #(
  parameter int SIG_W = 24,
  parameter int INT_W = 32,
  parameter int SH_W  = 5
) (
  input  logic [SIG_W-1:0] sig,
  input  logic             shiftRight,
  input  logic             shiftLeft,
  input  logic [SH_W-1:0]  shiftAmt,
  output logic [INT_W-1:0] mag
);

  logic [INT_W-1:0] sigWide;
  logic [INT_W-1:0] lStage [SH_W+1];
  logic [INT_W-1:0] rStage [SH_W+1];

  assign sigWide   = INT_W'(sig);
  assign lStage[0] = sigWide;
  assign rStage[0] = sigWide;

  // Logarithmic shifter, one stage per bit of the shift amount, in each direction.
  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    assign lStage[k+1] = shiftAmt[k] ? (lStage[k] << (2 ** k)) : lStage[k];
    assign rStage[k+1] = shiftAmt[k] ? (rStage[k] >> (2 ** k)) : rStage[k];
  end

  always_comb begin
    if (shiftLeft)       mag = lStage[SH_W];
    else if (shiftRight) mag = rStage[SH_W];
    else                 mag = '0;
  end

endmodule

// File: rtl/f2i_datapath.sv
module f2i_datapath
  import f2i_pkg::*;
#(
  parameter int FRAC_W = 23,
  parameter int INT_W  = 32,
  parameter int SH_W   = 5
) (
  input  logic [FRAC_W-1:0] frac,
  input  alignCtl_t         ctl,
  input  logic [SH_W-1:0]   shiftAmt,
  output logic [INT_W-1:0]  result
);

  localparam int SIG_W = FRAC_W + 1;
  localparam logic [INT_W-1:0] INT_MIN = {1'b1, {(INT_W-1){1'b0}}};

  logic [SIG_W-1:0] sig;
  logic [INT_W-1:0] mag;
  logic [INT_W-1:0] signedVal;

  assign sig = {1'b1, frac};

  f2i_align #(
    .SIG_W(SIG_W),
    .INT_W(INT_W),
    .SH_W (SH_W)
  ) align_i (
    .sig       (sig),
    .shiftRight(ctl.shiftRight),
    .shiftLeft (ctl.shiftLeft),
    .shiftAmt  (shiftAmt),
    .mag       (mag)
  );

  assign signedVal = ctl.negate ? (INT_W'(0) - mag) : mag;

  always_comb begin
    if (ctl.overflow)       result = INT_MIN;
    else if (ctl.flushZero) result = '0;
    else                    result = signedVal;
  end

endmodule

// File: rtl/float_to_int_trunc.sv
module float_to_int_trunc
  import f2i_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int INT_W  = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          inValid,
  input  logic [EXP_W+FRAC_W:0]         inWord,
  output logic                          outValid,
  output logic [INT_W-1:0]              outInt,
  output logic                          outOvf
);

  localparam int FLT_W    = 1 + EXP_W + FRAC_W;
  localparam int SH_W     = $clog2(INT_W);
  localparam int BIAS     = (2 ** (EXP_W - 1)) - 1;
  localparam int FLUSH_EX = BIAS + FRAC_W - INT_W;
  localparam int LIMIT_EX = BIAS + INT_W - 1;
  localparam logic [INT_W-1:0] INT_MIN  = {1'b1, {(INT_W-1){1'b0}}};
  localparam logic [FLT_W-1:0] MIN_WORD = {1'b1, EXP_W'(LIMIT_EX), {FRAC_W{1'b0}}};

  logic              signBit;
  logic [EXP_W-1:0]  expField;
  logic [FRAC_W-1:0] frac;
  alignCtl_t         ctl;
  logic [SH_W-1:0]   shiftAmt;
  logic [INT_W-1:0]  result;

  assign signBit  = inWord[FLT_W-1];
  assign expField = inWord[FLT_W-2 -: EXP_W];
  assign frac     = inWord[FRAC_W-1:0];

  f2i_ctrl #(
    .EXP_W (EXP_W),
    .FRAC_W(FRAC_W),
    .INT_W (INT_W),
    .SH_W  (SH_W)
  ) ctrl_i (
    .signBit (signBit),
    .expField(expField),
    .fracZero(~|frac),
    .ctl     (ctl),
    .shiftAmt(shiftAmt)
  );

  f2i_datapath #(
    .FRAC_W(FRAC_W),
    .INT_W (INT_W),
    .SH_W  (SH_W)
  ) dp_i (
    .frac    (frac),
    .ctl     (ctl),
    .shiftAmt(shiftAmt),
    .result  (result)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outInt   <= '0;
      outOvf   <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        outInt <= result;
        outOvf <= ctl.overflow;
      end
    end
  end

  // Control must never request two actions at once.
  assert_one_action_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.flushZero, ctl.shiftRight, ctl.shiftLeft, ctl.overflow}));

  assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && $stable(outInt) && $stable(outOvf)));

  assert_ovf_value_R4: assert property (@(posedge clk) disable iff (!rstN)
    outOvf |-> (outInt == INT_MIN));

  assert_nan_inf_R6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (&expField)) |=> outOvf);

  assert_flush_R3: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (expField <= EXP_W'(FLUSH_EX))) |=> ((outInt == '0) && !outOvf));

  assert_exact_min_R5: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (inWord == MIN_WORD)) |=> ((outInt == INT_MIN) && !outOvf));

endmodule

// File: tb/float_to_int_trunc_tb_top.sv
`timescale 1ns/100ps
module float_to_int_trunc_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] inWord = '0;
  logic        outValid;
  logic [31:0] outInt;
  logic        outOvf;

  int errCount = 0;
  int chkCount = 0;
  bit runDone = 1'b0;

  always #2.5 clk = ~clk;

  float_to_int_trunc dut_i (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inWord  (inWord),
    .outValid(outValid),
    .outInt  (outInt),
    .outOvf  (outOvf)
  );

  // Expected conversion from the numeric value, using real arithmetic.
  function automatic void refConv(input logic [31:0] w, output logic [31:0] res, output logic ovf);
    int  e;
    real r;
    e = int'(w[30:23]);
    if (e == 255) begin
      res = 32'h8000_0000; ovf = 1'b1; return;
    end
    if (e == 0) begin
      res = 32'd0; ovf = 1'b0; return;
    end
    r = (8388608.0 + real'(w[22:0])) * (2.0 ** (e - 150));
    if (w[31]) r = -r;
    if ((r >= 2147483648.0) || (r < -2147483648.0)) begin
      res = 32'h8000_0000; ovf = 1'b1;
    end else begin
      res = 32'($rtoi(r)); ovf = 1'b0;
    end
  endfunction

  function automatic string reqOf(input logic [31:0] w);
    if (w[30:23] == 8'hFF)       return "R6";
    if (w == 32'hCF00_0000)      return "R5";
    if (w[30:23] >= 8'd158)      return "R4";
    if (w[30:23] <= 8'd118)      return "R3";
    if (w[31])                   return "R7";
    if (w[30:23] < 8'd150)       return "R2";
    return "R1";
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    chkCount++;
    if (act !== exp) begin
      errCount++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  logic [31:0] lastInt;
  logic        lastOvf;

  // Present one word, then check it on the negedge after the capturing edge.
  task automatic applyWord(input logic [31:0] w);
    logic [31:0] eRes;
    logic        eOvf;
    string       req;
    refConv(w, eRes, eOvf);
    req = reqOf(w);
    @(negedge clk);
    inValid = 1'b1;
    inWord  = w;
    @(negedge clk);
    inValid = 1'b0;
    check("R8", "outValid", 32'(outValid), 32'd1);
    check(req, $sformatf("int for %h", w), outInt, eRes);
    check(req, $sformatf("flag for %h", w), 32'(outOvf), 32'(eOvf));
    lastInt = eRes;
    lastOvf = eOvf;
  endtask

  // A word with inValid low must not disturb the held result (R8).
  task automatic idleCheck(input logic [31:0] w);
    @(negedge clk);
    inValid = 1'b0;
    inWord  = w;
    @(negedge clk);
    check("R8", "outValid idle", 32'(outValid), 32'd0);
    check("R8", "outInt held", outInt, lastInt);
    check("R8", "outOvf held", 32'(outOvf), 32'(lastOvf));
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errCount, chkCount);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!runDone) begin
      chkCount++;
      errCount++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finishRun();
    end
  end

  initial begin
    logic [31:0] w;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R9", "outValid reset", 32'(outValid), 32'd0);
    check("R9", "outInt reset", outInt, 32'd0);
    check("R9", "outOvf reset", 32'(outOvf), 32'd0);
    rstN = 1'b1;

    // Directed corners
    applyWord(32'h3F80_0000); // R1: 1.0
    applyWord(32'h4B7F_FFFF); // R1: 16777215
    applyWord(32'h4EFF_FFFF); // R1: largest exponent 157
    idleCheck(32'hFFFF_FFFF);
    applyWord(32'h4030_0000); // R2: 2.75
    applyWord(32'h3F7F_BE77); // R2: 0.999
    applyWord(32'hC030_0000); // R2 R7: -2.75
    applyWord(32'hCEFF_FFFF); // R7: exponent 157 negative
    applyWord(32'h0000_0000); // R3: +0
    applyWord(32'h8000_0000); // R3: -0
    applyWord(32'h0000_0001); // R3: subnormal
    applyWord(32'h3B7F_FFFF); // R3: exponent 118
    applyWord(32'h3B80_0000); // R2: exponent 119 still below one
    applyWord(32'h4F00_0000); // R4: +2^31
    applyWord(32'hCF00_0001); // R4: just below -2^31
    applyWord(32'hCF00_0000); // R5: exactly -2^31
    idleCheck(32'h7F80_0000);
    applyWord(32'h7F7F_FFFF); // R4: largest finite
    applyWord(32'h7F80_0000); // R6: +inf
    applyWord(32'hFF80_0000); // R6: -inf
    applyWord(32'h7FC0_0001); // R6: NaN
    applyWord(32'h4B00_0001); // R1: exponent 150, no shift

    for (int i = 0; i < 1500; i++) begin
      w = $urandom;
      if (($urandom % 4) != 0) w[30:23] = 8'(100 + ($urandom % 80));
      applyWord(w);
      if ((i % 16) == 0) idleCheck($urandom);
    end

    runDone = 1'b1;
    finishRun();
  end

endmodule